// File: doc/BRIEF.md
# Decoded Switch and LED Port Bank

This block puts eight byte-wide port pairs on an isolated-I/O bus. Every address in a run of eight consecutive I/O locations stands for two ports: a read returns the byte from eight switch inputs, and a write loads the byte into eight LED drivers. The bus is a 16-bit address, a memory/IO qualifier, active-low read and write strobes, and a data bus split into an inbound byte, an outbound byte and an output enable. On the device side the block takes 64 switch lines and drives 64 LED lines.

The upper thirteen address bits must equal the fixed base pattern, and the qualifier must mark an I/O cycle, before any port is selected. The low three address bits then work like a 3-to-8 decoder and pull exactly one active-low line. A read drives the matching switch byte onto the bus while the read strobe is low. A write takes the address and data while the write strobe is low. The byte is committed when the strobe returns high, so only settled data reaches the LEDs.

Top module: `swled_port_bank`

## Requirements
- R1: When `iom` is 1 and `addr[15:3]` equals 13'b1100_1011_1111_0 (addresses CBF0h to CBF7h), exactly one bit of `sel_n` is 0, at index `addr[2:0]` (CBF4h gives `sel_n` = 8'hEF). Otherwise all bits of `sel_n` are 1.
- R2: While `rd_n` is 0 and a port is selected, `data_oe` is 1 and `data_out` equals `sw[8*k +: 8]`, where k is `addr[2:0]`.
- R3: `data_oe` is 0 whenever `rd_n` is 1 or no port is selected.
- R4: A write to port k loads `data_in` into `led[8*k +: 8]`. The load uses the values present while `wr_n` was low, happens on the first clock edge at which `wr_n` is sampled high after being low, and a 1 bit lights its LED.
- R5: While `wr_n` stays low, the `led` outputs do not change.
- R6: A write to port k leaves every other LED byte unchanged.
- R7: A write with `iom` at 0, or with an address outside CBF0h to CBF7h, changes no LED bit.
- R8: Reset (`rst_n` low) clears all 64 LED outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O port address |
| iom | input | 1 | 1 marks an I/O cycle, 0 marks a memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | Byte driven onto the bus by the processor |
| data_out | output | 8 | Byte driven onto the bus by the block |
| data_oe | output | 1 | 1 while the block drives the bus |
| sel_n | output | 8 | Active-low one-of-eight port selects |
| sw | input | 64 | Switch inputs; byte k belongs to port k |
| led | output | 64 | LED drivers; byte k belongs to port k |

## Verification
A stale write-strobe history register or a latched selection pointing at the wrong port shows at the `led` outputs. The byte lands in the wrong slot, or in no slot, one clock after the strobe rises. A load made during the low phase shows up before the strobe rises, which the check taken in the middle of a long write catches. Faults in the address match or the qualifier gating show at once on `sel_n` and `data_oe`, in the same cycle the address is presented, with no register in the path.

// File: rtl/swled_pkg.sv
package swled_pkg;
    localparam int SWLED_ADDR_W = 16;
    localparam int SWLED_DATA_W = 8;
    localparam int SWLED_PORTS  = 8;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2,
        BUS_BOTH  = 2'd3
    } bus_kind_e;

    function automatic bus_kind_e strobe_kind(input logic rd_n, input logic wr_n);
        return bus_kind_e'({~wr_n, ~rd_n});
    endfunction
endpackage

// File: rtl/swled_addr_decode.sv
module swled_addr_decode
    import swled_pkg::*;
#(
    parameter int ADDR_W = SWLED_ADDR_W,
    parameter int PORTS = SWLED_PORTS,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hCBF0
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     iom,
    input  logic                     rd_n,
    input  logic                     wr_n,
    output logic [PORTS-1:0]         sel_n,
    output logic [$clog2(PORTS)-1:0] idx,
    output logic                     rd_hit
);
    localparam int SEL_W = $clog2(PORTS);

    logic      block_hit;
    bus_kind_e kind;

    assign block_hit = iom && (addr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);
    assign idx = addr[SEL_W-1:0];
    assign kind = strobe_kind(rd_n, wr_n);
    assign rd_hit = block_hit && ((kind == BUS_READ) || (kind == BUS_BOTH));

    for (genvar g = 0; g < PORTS; g++) begin : g_line
        assign sel_n[g] = !(block_hit && (idx == SEL_W'(g)));
    end
endmodule

// File: rtl/swled_rd_mux.sv
module swled_rd_mux #(
    parameter int PORTS = 8,
    parameter int DATA_W = 8
) (
    input  logic [PORTS*DATA_W-1:0]  sw,
    input  logic [$clog2(PORTS)-1:0] idx,
    input  logic                     rd_hit,
    output logic [DATA_W-1:0]        data_out,
    output logic                     data_oe
);
    always_comb begin
        data_out = '0;
        data_oe  = rd_hit;
        if (rd_hit) begin
            data_out = sw[int'(idx)*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/swled_led_bank.sv
module swled_led_bank #(
    parameter int PORTS = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_n,
    input  logic [PORTS-1:0]        sel_n,
    input  logic [DATA_W-1:0]       data_in,
    output logic [PORTS*DATA_W-1:0] led
);
    typedef struct packed {
        logic                    wr_prev;
        logic [PORTS-1:0]        hit;
        logic [DATA_W-1:0]       wdata;
        logic [PORTS*DATA_W-1:0] led;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        wr_rise;

    always_comb begin
        st_d = st_q;
        st_d.wr_prev = wr_n;
        wr_rise = wr_n && !st_q.wr_prev;
        if (!wr_n) begin
            st_d.hit   = ~sel_n;
            st_d.wdata = data_in;
        end
        for (int i = 0; i < PORTS; i++) begin
            if (wr_rise && st_q.hit[i]) begin
                st_d.led[i*DATA_W +: DATA_W] = st_q.wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_prev <= 1'b1;
            st_q.hit     <= '0;
            st_q.wdata   <= '0;
            st_q.led     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led = st_q.led;
endmodule

// File: rtl/swled_port_bank.sv
module swled_port_bank
    import swled_pkg::*;
#(
    parameter int ADDR_W = SWLED_ADDR_W,
    parameter int DATA_W = SWLED_DATA_W,
    parameter int PORTS = SWLED_PORTS,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hCBF0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    iom,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [DATA_W-1:0]       data_in,
    output logic [DATA_W-1:0]       data_out,
    output logic                    data_oe,
    output logic [PORTS-1:0]        sel_n,
    input  logic [PORTS*DATA_W-1:0] sw,
    output logic [PORTS*DATA_W-1:0] led
);
    localparam int SEL_W = $clog2(PORTS);

    logic [SEL_W-1:0] idx;
    logic             rd_hit;

    swled_addr_decode #(.ADDR_W(ADDR_W), .PORTS(PORTS), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(addr), .iom(iom), .rd_n(rd_n), .wr_n(wr_n),
        .sel_n(sel_n), .idx(idx), .rd_hit(rd_hit)
    );

    swled_rd_mux #(.PORTS(PORTS), .DATA_W(DATA_W)) u_mux (
        .sw(sw), .idx(idx), .rd_hit(rd_hit),
        .data_out(data_out), .data_oe(data_oe)
    );

    swled_led_bank #(.PORTS(PORTS), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_n(sel_n),
        .data_in(data_in), .led(led)
    );
endmodule

// File: rtl/swled_port_bank_chk.sv
module swled_port_bank_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PORTS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr,
    input logic                    iom,
    input logic                    rd_n,
    input logic                    wr_n,
    input logic [DATA_W-1:0]       data_out,
    input logic                    data_oe,
    input logic [PORTS-1:0]        sel_n,
    input logic [PORTS*DATA_W-1:0] sw,
    input logic [PORTS*DATA_W-1:0] led
);
    localparam int SEL_W = $clog2(PORTS);

    logic wr_seen_q;
    logic rise_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen_q   <= 1'b1;
            rise_last_q <= 1'b0;
        end else begin
            wr_seen_q   <= wr_n;
            rise_last_q <= wr_n && !wr_seen_q;
        end
    end

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

    p_rd_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out == sw[int'(addr[SEL_W-1:0])*DATA_W +: DATA_W]));

    p_oe_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> !data_oe);

    p_led_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_last_q |-> $stable(led));

    p_iom_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !iom |-> (&sel_n && !data_oe));
endmodule

bind swled_port_bank swled_port_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(PORTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .iom(iom), .rd_n(rd_n),
    .wr_n(wr_n), .data_out(data_out), .data_oe(data_oe), .sel_n(sel_n),
    .sw(sw), .led(led)
);

// File: tb/swled_port_bank_test.sv
module swled_port_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // vector: [25] 1=write 0=read, [24] iom, [23:8] addr, [7:0] data
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 16'hCBF0, 8'hA5},
        {1'b1, 1'b1, 16'hCBF7, 8'h3C},
        {1'b1, 1'b1, 16'hCBF4, 8'hFF},
        {1'b1, 1'b0, 16'hCBF4, 8'h00},
        {1'b1, 1'b1, 16'hCBF8, 8'h11},
        {1'b1, 1'b1, 16'h4BF4, 8'h22},
        {1'b1, 1'b1, 16'hCBF4, 8'h0F},
        {1'b0, 1'b1, 16'hCBF4, 8'h00},
        {1'b0, 1'b1, 16'hCBF0, 8'h00},
        {1'b0, 1'b1, 16'hCBF7, 8'h00},
        {1'b0, 1'b0, 16'hCBF4, 8'h00},
        {1'b0, 1'b1, 16'hCBE7, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        iom = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [7:0]  sel_n;
    logic [63:0] sw = 64'h8877_6655_4433_2211;
    logic [63:0] led;
    logic [63:0] exp_led = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swled_port_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .iom(iom), .rd_n(rd_n),
        .wr_n(wr_n), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .sel_n(sel_n), .sw(sw), .led(led)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_range(input logic [15:0] a, input logic q);
        return q && (a[15:3] == 13'b1100_1011_1111_0);
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic q, input logic [7:0] d);
        @(negedge clk);
        addr = a; iom = q; data_in = d; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        iom = 1'b0; addr = '0;
        if (in_range(a, q)) exp_led[8*int'(a[2:0]) +: 8] = d;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic q);
        bit          hit;
        logic [7:0]  ebyte;
        @(negedge clk);
        addr = a; iom = q; rd_n = 1'b0;
        @(negedge clk);
        hit = in_range(a, q);
        ebyte = sw[8*int'(a[2:0]) +: 8];
        chk(data_oe == hit, hit ? "R2 oe" : "R3 oe", 64'(data_oe), 64'(hit));
        if (hit) chk(data_out == ebyte, "R2 data", 64'(data_out), 64'(ebyte));
        chk(sel_n == (hit ? ~(8'h1 << a[2:0]) : 8'hFF), "R1 sel_n", 64'(sel_n),
            64'(hit ? ~(8'h1 << a[2:0]) : 8'hFF));
        rd_n = 1'b1; iom = 1'b0; addr = '0;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(led == 64'h0, "R8 reset led", led, 64'h0);
        chk(data_oe == 1'b0, "R3 reset oe", 64'(data_oe), 64'h0);
        chk(sel_n == 8'hFF, "R1 reset sel_n", 64'(sel_n), 64'hFF);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][25]) begin
                bus_write(VEC[v][23:8], VEC[v][24], VEC[v][7:0]);
                // R4 load, R6 others kept, R7 ignored accesses
                chk(led == exp_led, "R4/R6/R7 led", led, exp_led);
            end else begin
                bus_read(VEC[v][23:8], VEC[v][24]);
            end
        end

        // R1: idle decode of CBF4h
        @(negedge clk);
        addr = 16'hCBF4; iom = 1'b1;
        #1 chk(sel_n == 8'hEF, "R1 idle sel_n", 64'(sel_n), 64'hEF);
        chk(data_oe == 1'b0, "R3 no strobe oe", 64'(data_oe), 64'h0);

        // R5: long write held low leaves LEDs untouched
        @(negedge clk);
        addr = 16'hCBF2; data_in = 8'h55; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(led == exp_led, "R5 held low", led, exp_led);
        wr_n = 1'b1;
        @(negedge clk);
        iom = 1'b0; addr = '0;
        exp_led[23:16] = 8'h55;
        chk(led == exp_led, "R4 after rise", led, exp_led);

        // R8: reset mid-run clears LEDs
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk(led == 64'h0, "R8 rerun reset", led, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule